// File: doc/BRIEF.md
# SHA-1 Message Block Formatter

This block builds the one 512-bit input block of a keyed SHA-1 digest and hands it to a hash core. The block is sent as sixteen 32-bit words, in ascending word order, each on a valid/ready handshake. The keyed message draws on four sources:

- an eight-byte secret, held at the top of a byte-addressed memory;
- one 32-byte page of that memory, chosen by a page index;
- seven identity bytes, given on a parallel input;
- three challenge bytes, given on a parallel input.

The block adds a tag byte, a constant filler word and the fixed SHA-1 padding and length for a 55-byte message.

A `start` pulse in idle latches the three target-address bits that form the tag and the page index. The block then walks the sixteen words. Words that need memory are gathered through a single byte-read port. That port returns data one cycle after the request. All other words are built from constants and the parallel inputs. Each finished word is held in an output register until the consumer accepts it.

Top module: `msgblk_fmt`

## Requirements
- R1: While reset is asserted, and from the first cycle after it, `out_valid`, `busy` and `mem_rd_en` are 0.
- R2: After a `start` pulse in idle, sixteen words are offered with `out_idx` 0 to 15 in order, one per accepted handshake. `out_last` is 1 only with index 15.
- R3: Word 0 is memory bytes SECRET_BASE+0..3 and word 12 is SECRET_BASE+4..7. The lowest address goes in bits [31:24].
- R4: Word k (k = 1..8) is memory bytes page_idx*32 + 4*(k-1) + 0..3. The lowest address goes in bits [31:24].
- R5: Word 9 is FFFFFFFFh.
- R6: Word 10 is {tag, id0, id1, id2} and word 11 is {id3, id4, id5, id6}. The tag byte is {01000b, start_hi[2:0]}. Identity byte n sits at `id_in[8n+7:8n]`.
- R7: Word 13 is {ch0, ch1, ch2, 80h}, where challenge byte k sits at `chal_in[8k+7:8k]`. Word 14 is 0 and word 15 is 000001B8h.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_word`, `out_idx` and `out_last` hold their values.
- R9: `start`, `start_hi` and `page_idx` are ignored while `busy` is 1. The running block keeps the tag and page latched at its start.
- R10: A block makes exactly 40 memory reads: four per memory word. Every read address is below SECRET_BASE+8.
- R11: `busy` is 1 from the cycle after an accepted `start` until the cycle after word 15 is accepted, and 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a block (idle only) |
| start_hi | input | 3 | Target-address bits 7:5, used in the tag byte |
| page_idx | input | PAGE_W | Page selector |
| id_in | input | 56 | Identity bytes 0..6 |
| chal_in | input | 24 | Challenge bytes |
| mem_rd_en | output | 1 | Memory byte read request |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| out_valid | output | 1 | Word offered |
| out_ready | input | 1 | Consumer accepts the word |
| out_word | output | 32 | Message word |
| out_idx | output | 4 | Word index 0..15 |
| out_last | output | 1 | Final word of the block |
| busy | output | 1 | A block is in progress |

## Verification
The bench builds the block with its defaults: an 8-bit address, the secret base at 80h and a 2-bit page index. With these values every page base (00h, 20h, 40h, 60h) and the secret region fall inside one 256-byte bench memory. The vectors cover all four pages, five of the eight tag values, stalls of zero to three cycles and a competing `start` in the middle of a block. A reset applied mid-block is checked to bring the block back to idle.

// File: rtl/msgblk_pkg.sv
package msgblk_pkg;
    localparam int WORD_W     = 32;
    localparam int WORD_CNT   = 16;
    localparam int IDX_W      = $clog2(WORD_CNT);
    localparam int BYTES_PW   = WORD_W / 8;
    localparam int PAGE_BYTES = 32;
    localparam int PAGE_OFS_W = $clog2(PAGE_BYTES);
    localparam int ID_BYTES   = 7;
    localparam int CHAL_BYTES = 3;

    localparam logic [4:0]        TAG_HI    = 5'b01000;
    localparam logic [WORD_W-1:0] FILL_WORD = 32'hFFFF_FFFF;
    localparam logic [7:0]        PAD_BYTE  = 8'h80;
    localparam logic [WORD_W-1:0] LEN_WORD  = 32'h0000_01B8;

    localparam logic [IDX_W-1:0] IDX_SEC_LO  = 4'd0;
    localparam logic [IDX_W-1:0] IDX_PG_FIRST = 4'd1;
    localparam logic [IDX_W-1:0] IDX_PG_LAST = 4'd8;
    localparam logic [IDX_W-1:0] IDX_FILL    = 4'd9;
    localparam logic [IDX_W-1:0] IDX_ID_LO   = 4'd10;
    localparam logic [IDX_W-1:0] IDX_ID_HI   = 4'd11;
    localparam logic [IDX_W-1:0] IDX_SEC_HI  = 4'd12;
    localparam logic [IDX_W-1:0] IDX_CHAL    = 4'd13;
    localparam logic [IDX_W-1:0] IDX_ZERO    = 4'd14;
    localparam logic [IDX_W-1:0] IDX_LEN     = 4'd15;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_SHOW  = 2'd2
    } fmt_st_e;

    function automatic logic is_page_word(input logic [IDX_W-1:0] idx);
        return (idx >= IDX_PG_FIRST) && (idx <= IDX_PG_LAST);
    endfunction

    function automatic logic is_mem_word(input logic [IDX_W-1:0] idx);
        return (idx == IDX_SEC_LO) || (idx == IDX_SEC_HI) || is_page_word(idx);
    endfunction
endpackage

// File: rtl/msgblk_addr_gen.sv
module msgblk_addr_gen
    import msgblk_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SECRET_BASE = 128,
    parameter int PAGE_W      = 2
) (
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [1:0]        byte_sel,
    input  logic [PAGE_W-1:0] page,
    output logic              uses_mem,
    output logic [ADDR_W-1:0] addr
);
    localparam int PG_ADDR_W = PAGE_W + PAGE_OFS_W;

    logic [IDX_W-1:0]     pg_word;
    logic [PAGE_OFS_W-1:0] pg_ofs;
    logic [PG_ADDR_W-1:0] pg_addr;
    logic [2:0]           sec_ofs;

    always_comb begin
        pg_word  = word_idx - IDX_PG_FIRST;
        pg_ofs   = {pg_word[PAGE_OFS_W-3:0], byte_sel};
        pg_addr  = {page, pg_ofs};
        sec_ofs  = {word_idx == IDX_SEC_HI, byte_sel};
        uses_mem = is_mem_word(word_idx);
        if (is_page_word(word_idx)) begin
            addr = ADDR_W'(pg_addr);
        end else begin
            addr = ADDR_W'(SECRET_BASE) + ADDR_W'(sec_ofs);
        end
    end
endmodule

// File: rtl/msgblk_word_mux.sv
module msgblk_word_mux
    import msgblk_pkg::*;
(
    input  logic [IDX_W-1:0]      word_idx,
    input  logic [2:0]            tag_lo,
    input  logic [8*ID_BYTES-1:0] id_in,
    input  logic [8*CHAL_BYTES-1:0] chal_in,
    output logic [WORD_W-1:0]     word
);
    logic [7:0] id_b   [ID_BYTES];
    logic [7:0] chal_b [CHAL_BYTES];
    logic [7:0] tag;

    for (genvar i = 0; i < ID_BYTES; i++) begin : g_id
        assign id_b[i] = id_in[8*i +: 8];
    end
    for (genvar i = 0; i < CHAL_BYTES; i++) begin : g_chal
        assign chal_b[i] = chal_in[8*i +: 8];
    end

    assign tag = {TAG_HI, tag_lo};

    always_comb begin
        unique case (word_idx)
            IDX_FILL:  word = FILL_WORD;
            IDX_ID_LO: word = {tag, id_b[0], id_b[1], id_b[2]};
            IDX_ID_HI: word = {id_b[3], id_b[4], id_b[5], id_b[6]};
            IDX_CHAL:  word = {chal_b[0], chal_b[1], chal_b[2], PAD_BYTE};
            IDX_LEN:   word = LEN_WORD;
            default:   word = '0;
        endcase
    end
endmodule

// File: rtl/msgblk_fmt.sv
module msgblk_fmt
    import msgblk_pkg::*;
#(
    parameter int ADDR_W      = 8,
    parameter int SECRET_BASE = 128,
    parameter int PAGE_W      = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [2:0]              start_hi,
    input  logic [PAGE_W-1:0]       page_idx,
    input  logic [8*ID_BYTES-1:0]   id_in,
    input  logic [8*CHAL_BYTES-1:0] chal_in,
    output logic                    mem_rd_en,
    output logic [ADDR_W-1:0]       mem_addr,
    input  logic [7:0]              mem_rdata,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [WORD_W-1:0]       out_word,
    output logic [IDX_W-1:0]        out_idx,
    output logic                    out_last,
    output logic                    busy
);
    localparam logic [2:0] LAST_BYTE_CNT = 3'(BYTES_PW);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_CNT - 1);

    typedef struct packed {
        fmt_st_e           st;
        logic [IDX_W-1:0]  idx;
        logic [2:0]        cnt;
        logic [WORD_W-1:0] word;
        logic [2:0]        tag;
        logic [PAGE_W-1:0] page;
    } fmt_state_t;

    fmt_state_t r_q, r_d;

    logic              uses_mem;
    logic [WORD_W-1:0] const_word;

    msgblk_addr_gen #(
        .ADDR_W      (ADDR_W),
        .SECRET_BASE (SECRET_BASE),
        .PAGE_W      (PAGE_W)
    ) addr_gen_i (
        .word_idx (r_q.idx),
        .byte_sel (r_q.cnt[1:0]),
        .page     (r_q.page),
        .uses_mem (uses_mem),
        .addr     (mem_addr)
    );

    msgblk_word_mux word_mux_i (
        .word_idx (r_q.idx),
        .tag_lo   (r_q.tag),
        .id_in    (id_in),
        .chal_in  (chal_in),
        .word     (const_word)
    );

    always_comb begin
        r_d       = r_q;
        mem_rd_en = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st   = ST_FETCH;
                    r_d.idx  = '0;
                    r_d.cnt  = '0;
                    r_d.tag  = start_hi;
                    r_d.page = page_idx;
                end
            end
            ST_FETCH: begin
                if (!uses_mem) begin
                    r_d.word = const_word;
                    r_d.st   = ST_SHOW;
                end else begin
                    mem_rd_en = (r_q.cnt != LAST_BYTE_CNT);
                    if (r_q.cnt != 3'd0) begin
                        r_d.word = {r_q.word[WORD_W-9:0], mem_rdata};
                    end
                    if (r_q.cnt == LAST_BYTE_CNT) begin
                        r_d.cnt = '0;
                        r_d.st  = ST_SHOW;
                    end else begin
                        r_d.cnt = r_q.cnt + 3'd1;
                    end
                end
            end
            ST_SHOW: begin
                if (out_ready) begin
                    if (r_q.idx == LAST_IDX) begin
                        r_d.st = ST_IDLE;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ST_FETCH;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign out_valid = (r_q.st == ST_SHOW);
    assign out_word  = r_q.word;
    assign out_idx   = r_q.idx;
    assign out_last  = out_valid && (r_q.idx == LAST_IDX);
    assign busy      = (r_q.st != ST_IDLE);
endmodule

// File: rtl/msgblk_fmt_chk.sv
module msgblk_fmt_chk #(
    parameter int ADDR_W      = 8,
    parameter int SECRET_BASE = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              mem_rd_en,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              out_valid,
    input logic              out_ready,
    input logic [31:0]       out_word,
    input logic [3:0]        out_idx,
    input logic              out_last
);
    localparam int ADDR_LIMIT = SECRET_BASE + 8;

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!out_valid && !mem_rd_en));

    // R8
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_word) && $stable(out_idx) && $stable(out_last)));

    // R10
    read_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> (int'(mem_addr) < ADDR_LIMIT));

    // R11
    done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_last) |=> !busy);

    // R11
    stay_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> busy);

    // R9
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(out_valid && out_ready && out_last)) |=> busy);

    // R2
    next_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !out_last) |=> (out_idx == $past(out_idx) + 4'd1));

    // R5
    fill_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx == 4'd9) |-> (out_word == 32'hFFFF_FFFF));

    // R7
    length_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_idx == 4'd15) |-> (out_word == 32'h0000_01B8));
endmodule

bind msgblk_fmt msgblk_fmt_chk #(
    .ADDR_W      (ADDR_W),
    .SECRET_BASE (SECRET_BASE)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .mem_rd_en (mem_rd_en),
    .mem_addr  (mem_addr),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_idx   (out_idx),
    .out_last  (out_last)
);

// File: tb/msgblk_fmt_tb.sv
`timescale 1ns/1ps
module msgblk_fmt_tb_top;
    localparam int ADDR_W = 8;
    localparam int SECRET_BASE = 128;
    localparam int PAGE_W = 2;

    typedef struct packed {
        logic [2:0] hi;
        logic [1:0] pg;
        logic [7:0] seed;
        logic [1:0] stall;
        logic       disturb;
    } vec_t;

    localparam int NVEC = 5;
    localparam vec_t VECS [NVEC] = '{
        '{hi: 3'b000, pg: 2'd0, seed: 8'h11, stall: 2'd0, disturb: 1'b0},
        '{hi: 3'b111, pg: 2'd3, seed: 8'h5A, stall: 2'd2, disturb: 1'b0},
        '{hi: 3'b101, pg: 2'd1, seed: 8'hC3, stall: 2'd0, disturb: 1'b1},
        '{hi: 3'b010, pg: 2'd2, seed: 8'h07, stall: 2'd3, disturb: 1'b1},
        '{hi: 3'b100, pg: 2'd0, seed: 8'hF0, stall: 2'd1, disturb: 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        start_hi = '0;
    logic [PAGE_W-1:0] page_idx = '0;
    logic [55:0]       id_in = '0;
    logic [23:0]       chal_in = '0;
    logic              mem_rd_en;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_rdata = '0;
    logic              out_valid;
    logic              out_ready = 1'b0;
    logic [31:0]       out_word;
    logic [3:0]        out_idx;
    logic              out_last;
    logic              busy;

    logic [7:0] mem [256];
    int rd_cnt = 0;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rdata <= mem[mem_addr];
            rd_cnt <= rd_cnt + 1;
        end
    end

    msgblk_fmt #(
        .ADDR_W      (ADDR_W),
        .SECRET_BASE (SECRET_BASE),
        .PAGE_W      (PAGE_W)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .start_hi  (start_hi),
        .page_idx  (page_idx),
        .id_in     (id_in),
        .chal_in   (chal_in),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_word  (out_word),
        .out_idx   (out_idx),
        .out_last  (out_last),
        .busy      (busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fill_mem(input logic [7:0] seed);
        for (int a = 0; a < 256; a++) mem[a] = 8'(a * 3) + seed;
    endtask

    function automatic string req_of(input int w);
        if (w == 0 || w == 12) return "R3";
        if (w >= 1 && w <= 8) return "R4";
        if (w == 9) return "R5";
        if (w == 10 || w == 11) return "R6";
        return "R7";
    endfunction

    function automatic logic [31:0] exp_word(input int w, input logic [2:0] hi,
                                             input logic [1:0] pg, input logic [55:0] id,
                                             input logic [23:0] ch);
        logic [7:0] b [4];
        for (int k = 0; k < 4; k++) b[k] = 8'h00;
        case (w)
            0:  for (int k = 0; k < 4; k++) b[k] = mem[SECRET_BASE + k];
            12: for (int k = 0; k < 4; k++) b[k] = mem[SECRET_BASE + 4 + k];
            9:  for (int k = 0; k < 4; k++) b[k] = 8'hFF;
            10: begin
                b[0] = {5'b01000, hi};
                for (int k = 1; k < 4; k++) b[k] = id[8*(k-1) +: 8];
            end
            11: for (int k = 0; k < 4; k++) b[k] = id[8*(k+3) +: 8];
            13: begin
                for (int k = 0; k < 3; k++) b[k] = ch[8*k +: 8];
                b[3] = 8'h80;
            end
            15: begin b[2] = 8'h01; b[3] = 8'hB8; end
            default: begin
                if (w >= 1 && w <= 8)
                    for (int k = 0; k < 4; k++) b[k] = mem[int'(pg) * 32 + (w - 1) * 4 + k];
            end
        endcase
        return {b[0], b[1], b[2], b[3]};
    endfunction

    task automatic run_vec(input vec_t v);
        logic [55:0] id;
        logic [23:0] ch;
        int rd_start;
        logic [31:0] held;
        id = {7{v.seed}} ^ 56'h0123_4567_89AB_CD;
        ch = {3{v.seed}} ^ 24'hE1_D2_C3;
        fill_mem(v.seed);
        id_in = id;
        chal_in = ch;
        start_hi = v.hi;
        page_idx = v.pg;
        rd_start = rd_cnt;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R11", 32'(busy), 32'd1);
        for (int w = 0; w < 16; w++) begin
            if (v.disturb && w == 5) begin
                start = 1'b1;
                start_hi = ~v.hi;
                page_idx = ~v.pg;
                @(negedge clk);
                start = 1'b0;
            end
            while (!out_valid) @(negedge clk);
            // R2 order and last flag
            chk("R2", 32'(out_idx), 32'(w));
            chk("R2", 32'(out_last), 32'(w == 15));
            chk(req_of(w), out_word, exp_word(w, v.hi, v.pg, id, ch));
            held = out_word;
            for (int s = 0; s < int'(v.stall); s++) begin
                @(negedge clk);
                // R8 hold while stalled
                chk("R8", {out_valid, 27'd0, out_idx}, {1'b1, 27'd0, 4'(w)});
                chk("R8", out_word, held);
            end
            out_ready = 1'b1;
            @(negedge clk);
            out_ready = 1'b0;
        end
        // R11 idle after last accepted
        chk("R11", 32'(busy), 32'd0);
        // R10 four reads per memory word
        chk("R10", 32'(rd_cnt - rd_start), 32'd40);
        if (v.disturb) chk("R9", 32'(busy), 32'd0);
        start_hi = v.hi;
        page_idx = v.pg;
    endtask

    initial begin
        #(8 * 150000);
        bad++;
        $display("FAIL R11 watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", {29'd0, out_valid, busy, mem_rd_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {29'd0, out_valid, busy, mem_rd_en}, 32'd0);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R1 reset in the middle of a block returns to idle
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (7) @(negedge clk);
        chk("R11", 32'(busy), 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1", {29'd0, out_valid, busy, mem_rd_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", {29'd0, out_valid, busy, mem_rd_en}, 32'd0);

        // a full block after the mid-block reset
        run_vec(VECS[1]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule